// File: doc/BRIEF.md
# Return Target Predictor

This block guesses where a subroutine return will jump, so that a pipelined 8-bit processor front end can redirect fetch without waiting for the stack read. When a call retires its push, the block writes the full 16-bit return address into a small table. The table slot is chosen from a few low bits of the stack pointer. At fetch, a separate branch-target lookup may mark the current instruction as a return. In that case, and in the same cycle, the block supplies the stored address as the predicted target.

Later in the pipeline, the real return address is popped from the stack. The block adds one to it and checks it against the guess that travelled down the pipe with the instruction. A wrong guess produces a flush and a redirect to the corrected address. A return that was never predicted, because the branch-target lookup had no entry or the slot was empty, produces a plain redirect with no flush.

Every prediction is checked against the real stack contents. Stack manipulation by software, or call nesting deeper than the table, therefore costs only a mispredict and never a wrong result.

There is no back-pressure on any interface. Each `*_vld` strobe is a single-cycle event that the block always accepts in the cycle it is raised. The pipeline that owns this block must not stall it.

Top module: `ret_addr_predictor`

## Requirements
- R1: After reset every table slot is empty, so a return query at any stack pointer gives `pred_vld` = 0.
- R2: A call (`call_vld` = 1) writes `call_ret_addr` into slot `call_sp[IDXW:1]`, where IDXW = log2(ENTRIES). `call_sp` is the stack pointer after the call's pushes. A later return query whose `fq_sp` (the pointer before the pop) has the same bits gives `pred_vld` = 1 and `pred_tgt` = that address, in the same cycle as the query.
- R3: `pred_vld` is 0 whenever `fq_vld` is 0 or `fq_is_ret` is 0, whatever the table holds.
- R4: A return query that selects a slot never written since reset gives `pred_vld` = 0.
- R5: If a call write and a return query select the same slot in the same cycle, the query sees the address being written (`pred_vld` = 1, `pred_tgt` = `call_ret_addr`), even if the slot was empty.
- R6: Stack pointer bit 0 and the bits above IDXW take no part in slot selection.
- R7: One clock after `rs_vld`, `redir_tgt` equals `rs_popped` + 1 modulo 2^16, so 16'hFFFF becomes 16'h0000. `redir_vld` and `redir_flush` are high for at most that one cycle and are 0 in any cycle that follows a cycle without `rs_vld`.
- R8: A predicted return (`rs_hit` = 1) whose `rs_pred_tgt` equals `rs_popped` + 1 raises neither `redir_vld` nor `redir_flush`.
- R9: A predicted return whose `rs_pred_tgt` differs from `rs_popped` + 1 raises `redir_vld` and `redir_flush` together one cycle later.
- R10: An unpredicted return (`rs_hit` = 0) raises `redir_vld` with `redir_flush` = 0 one cycle later.
- R11: A later call to a slot replaces the address held there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_vld | input | 1 | Call event strobe |
| call_sp | input | SPW | Stack pointer after the call's pushes |
| call_ret_addr | input | AW | Return address to record |
| fq_vld | input | 1 | Fetch query strobe |
| fq_is_ret | input | 1 | Branch-target lookup marks this fetch as a return |
| fq_sp | input | SPW | Stack pointer before the return's pop |
| pred_vld | output | 1 | Prediction available (combinational) |
| pred_tgt | output | AW | Predicted return target |
| rs_vld | input | 1 | Resolution strobe for a return |
| rs_hit | input | 1 | This return was predicted at fetch |
| rs_pred_tgt | input | AW | Target that was predicted |
| rs_popped | input | AW | Return address read from the stack |
| redir_vld | output | 1 | Redirect fetch to `redir_tgt` |
| redir_flush | output | 1 | Redirect caused by a misprediction; flush younger work |
| redir_tgt | output | AW | Resolved target (popped + 1) |

## Verification
The prediction is combinational from the table. The bench therefore checks `pred_vld` and `pred_tgt` one nanosecond after driving a query at the falling edge, before the next rising edge. A call written at one falling edge is visible to queries from the following falling edge onward, and a same-cycle call is checked through the bypass. The resolution outputs pass through one register. The bench raises `rs_vld` at a falling edge, samples the redirect at the next falling edge, and checks at the falling edge after that that the pulse has dropped again.

// File: rtl/rap_pkg.sv
`timescale 1ns/1ps
package rap_pkg;
  // Outcome of one return resolution.
  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,  // prediction confirmed, nothing to do
    RES_JUMP  = 2'd1,  // no prediction was made: plain redirect
    RES_FLUSH = 2'd2   // prediction wrong: flush and redirect
  } res_kind_e;

  function automatic logic kind_redirects(res_kind_e k);
    return (k == RES_JUMP) || (k == RES_FLUSH);
  endfunction
endpackage

// File: rtl/rap_table.sv
`timescale 1ns/1ps
// Slot storage: per-slot valid bit (reset) and address word (no reset).
module rap_table #(
  parameter int ENTRIES = 16,
  parameter int AW      = 16,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [AW-1:0]   wr_addr,
  input  logic [IDXW-1:0] rd_idx,
  output logic            rd_vld,
  output logic [AW-1:0]   rd_addr
);
  logic [ENTRIES-1:0] slot_vld;
  logic [AW-1:0]      slot_addr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDXW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_vld[g] <= 1'b0;
      else if (sel) slot_vld[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) slot_addr[g] <= wr_addr;
    end
  end

  assign rd_vld  = slot_vld[rd_idx];
  assign rd_addr = slot_addr[rd_idx];
endmodule

// File: rtl/rap_lookup.sv
`timescale 1ns/1ps
// Fetch-side gating plus same-cycle write-to-read bypass.
module rap_lookup #(
  parameter int ENTRIES = 16,
  parameter int AW      = 16,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic            q_vld,
  input  logic            q_is_ret,
  input  logic [IDXW-1:0] q_idx,
  input  logic            tbl_vld,
  input  logic [AW-1:0]   tbl_addr,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [AW-1:0]   wr_addr,
  output logic            pred_vld,
  output logic [AW-1:0]   pred_tgt
);
  logic fwd;
  assign fwd = wr_en && (wr_idx == q_idx);

  always_comb begin
    pred_tgt = fwd ? wr_addr : tbl_addr;
    pred_vld = q_vld && q_is_ret && (fwd || tbl_vld);
  end
endmodule

// File: rtl/rap_resolve.sv
`timescale 1ns/1ps
// Increment the popped address, compare with the guess, register outcome.
module rap_resolve
  import rap_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rs_vld,
  input  logic          rs_hit,
  input  logic [AW-1:0] rs_pred_tgt,
  input  logic [AW-1:0] rs_popped,
  output logic          redir_vld,
  output logic          redir_flush,
  output logic [AW-1:0] redir_tgt
);
  logic [AW-1:0] tgt_nxt;
  res_kind_e     kind_nxt, kind_q;

  assign tgt_nxt = rs_popped + AW'(1);

  always_comb begin
    if (!rs_vld)                     kind_nxt = RES_NONE;
    else if (!rs_hit)                kind_nxt = RES_JUMP;
    else if (rs_pred_tgt != tgt_nxt) kind_nxt = RES_FLUSH;
    else                             kind_nxt = RES_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q    <= RES_NONE;
      redir_tgt <= '0;
    end else begin
      kind_q <= kind_nxt;
      if (rs_vld) redir_tgt <= tgt_nxt;
    end
  end

  assign redir_vld   = kind_redirects(kind_q);
  assign redir_flush = (kind_q == RES_FLUSH);
endmodule

// File: rtl/ret_addr_predictor.sv
`timescale 1ns/1ps
module ret_addr_predictor #(
  parameter int ENTRIES = 16,
  parameter int AW      = 16,
  parameter int SPW     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           call_vld,
  input  logic [SPW-1:0] call_sp,
  input  logic [AW-1:0]  call_ret_addr,
  input  logic           fq_vld,
  input  logic           fq_is_ret,
  input  logic [SPW-1:0] fq_sp,
  output logic           pred_vld,
  output logic [AW-1:0]  pred_tgt,
  input  logic           rs_vld,
  input  logic           rs_hit,
  input  logic [AW-1:0]  rs_pred_tgt,
  input  logic [AW-1:0]  rs_popped,
  output logic           redir_vld,
  output logic           redir_flush,
  output logic [AW-1:0]  redir_tgt
);
  localparam int IDXW = $clog2(ENTRIES);

  if (ENTRIES < 4 || ENTRIES > 16 || (1 << IDXW) != ENTRIES || IDXW + 2 > SPW)
    begin : g_bad_cfg
      $error("ret_addr_predictor: ENTRIES must be a power of two in 4..16");
    end

  // Slot index is stack pointer / 2, truncated to the table size.
  logic [IDXW-1:0] wr_idx, rd_idx;
  assign wr_idx = call_sp[IDXW:1];
  assign rd_idx = fq_sp[IDXW:1];

  logic unused_sp_bits;
  assign unused_sp_bits = ^{call_sp[0], call_sp[SPW-1:IDXW+1],
                            fq_sp[0],   fq_sp[SPW-1:IDXW+1]};

  logic          tbl_vld;
  logic [AW-1:0] tbl_addr;

  rap_table #(.ENTRIES(ENTRIES), .AW(AW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (call_vld),
    .wr_idx  (wr_idx),
    .wr_addr (call_ret_addr),
    .rd_idx  (rd_idx),
    .rd_vld  (tbl_vld),
    .rd_addr (tbl_addr)
  );

  rap_lookup #(.ENTRIES(ENTRIES), .AW(AW)) u_lookup (
    .q_vld    (fq_vld),
    .q_is_ret (fq_is_ret),
    .q_idx    (rd_idx),
    .tbl_vld  (tbl_vld),
    .tbl_addr (tbl_addr),
    .wr_en    (call_vld),
    .wr_idx   (wr_idx),
    .wr_addr  (call_ret_addr),
    .pred_vld (pred_vld),
    .pred_tgt (pred_tgt)
  );

  rap_resolve #(.AW(AW)) u_resolve (
    .clk         (clk),
    .rst_n       (rst_n),
    .rs_vld      (rs_vld),
    .rs_hit      (rs_hit),
    .rs_pred_tgt (rs_pred_tgt),
    .rs_popped   (rs_popped),
    .redir_vld   (redir_vld),
    .redir_flush (redir_flush),
    .redir_tgt   (redir_tgt)
  );
endmodule

// File: rtl/rap_checker.sv
`timescale 1ns/1ps
module rap_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fq_vld,
  input logic          fq_is_ret,
  input logic          pred_vld,
  input logic          rs_vld,
  input logic          rs_hit,
  input logic [AW-1:0] rs_pred_tgt,
  input logic [AW-1:0] rs_popped,
  input logic          redir_vld,
  input logic          redir_flush,
  input logic [AW-1:0] redir_tgt
);
  logic [AW-1:0] pop_inc;
  assign pop_inc = rs_popped + AW'(1);

  AST_PRED_NEEDS_RET: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vld |-> (fq_vld && fq_is_ret)); // R3

  AST_QUIET_WITHOUT_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_vld |=> (!redir_vld && !redir_flush)); // R7

  AST_REDIR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    rs_vld |=> (redir_tgt == $past(pop_inc))); // R7

  AST_MATCH_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_vld && rs_hit && rs_pred_tgt == pop_inc) |=> !redir_vld); // R8

  AST_MISMATCH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_vld && rs_hit && rs_pred_tgt != pop_inc) |=> (redir_vld && redir_flush)); // R9

  AST_FLUSH_HAS_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    redir_flush |-> redir_vld); // R9

  AST_UNPRED_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_vld && !rs_hit) |=> (redir_vld && !redir_flush)); // R10
endmodule

bind ret_addr_predictor rap_checker #(.AW(AW)) u_rap_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .fq_vld      (fq_vld),
  .fq_is_ret   (fq_is_ret),
  .pred_vld    (pred_vld),
  .rs_vld      (rs_vld),
  .rs_hit      (rs_hit),
  .rs_pred_tgt (rs_pred_tgt),
  .rs_popped   (rs_popped),
  .redir_vld   (redir_vld),
  .redir_flush (redir_flush),
  .redir_tgt   (redir_tgt)
);

// File: tb/ret_addr_predictor_bench.sv
`timescale 1ns/1ps
module ret_addr_predictor_bench;
  localparam int ENTRIES = 16;
  localparam int AW      = 16;
  localparam int SPW     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           call_vld = 0, fq_vld = 0, fq_is_ret = 0;
  logic [SPW-1:0] call_sp = '0, fq_sp = '0;
  logic [AW-1:0]  call_ret_addr = '0;
  logic           pred_vld, redir_vld, redir_flush;
  logic [AW-1:0]  pred_tgt, redir_tgt;
  logic           rs_vld = 0, rs_hit = 0;
  logic [AW-1:0]  rs_pred_tgt = '0, rs_popped = '0;

  ret_addr_predictor #(.ENTRIES(ENTRIES), .AW(AW), .SPW(SPW)) u_ret_addr_predictor (
    .clk(clk), .rst_n(rst_n),
    .call_vld(call_vld), .call_sp(call_sp), .call_ret_addr(call_ret_addr),
    .fq_vld(fq_vld), .fq_is_ret(fq_is_ret), .fq_sp(fq_sp),
    .pred_vld(pred_vld), .pred_tgt(pred_tgt),
    .rs_vld(rs_vld), .rs_hit(rs_hit), .rs_pred_tgt(rs_pred_tgt), .rs_popped(rs_popped),
    .redir_vld(redir_vld), .redir_flush(redir_flush), .redir_tgt(redir_tgt)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic          ref_v [ENTRIES];
  logic [AW-1:0] ref_a [ENTRIES];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [SPW-1:0] sp_of(input int slot, input logic [2:0] hi, input bit b0);
    return {hi, 4'(slot), b0};
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic do_call(input int slot, input logic [AW-1:0] a);
    call_vld = 1; call_sp = sp_of(slot, 3'b000, 1'b0); call_ret_addr = a;
    @(negedge clk);
    call_vld = 0;
    ref_v[slot] = 1; ref_a[slot] = a;
  endtask

  task automatic do_query(input logic [SPW-1:0] sp, input bit q, input bit r,
                          input bit ev, input logic [AW-1:0] ea, input string req);
    fq_vld = q; fq_is_ret = r; fq_sp = sp;
    #1;
    chk(pred_vld == ev, req, {31'd0, pred_vld}, {31'd0, ev});
    if (ev) chk(pred_tgt == ea, req, {16'd0, pred_tgt}, {16'd0, ea});
    @(negedge clk);
    fq_vld = 0; fq_is_ret = 0;
  endtask

  task automatic do_resolve(input bit hit, input logic [AW-1:0] pt,
                            input logic [AW-1:0] pop, input string req);
    logic [AW-1:0] exp_t;
    bit ev, ef;
    exp_t = AW'((32'(pop) + 1) % 32'h10000);
    ef = hit && (pt != exp_t);
    ev = !hit || ef;
    rs_vld = 1; rs_hit = hit; rs_pred_tgt = pt; rs_popped = pop;
    @(negedge clk);
    rs_vld = 0;
    chk(redir_vld == ev, req, {31'd0, redir_vld}, {31'd0, ev});
    chk(redir_flush == ef, req, {31'd0, redir_flush}, {31'd0, ef});
    chk(redir_tgt == exp_t, "R7", {16'd0, redir_tgt}, {16'd0, exp_t});
    @(negedge clk);
    chk(!redir_vld && !redir_flush, "R7 one-cycle pulse",
        {30'd0, redir_vld, redir_flush}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin ref_v[i] = 0; ref_a[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!redir_vld && !redir_flush, "R1 reset outputs", {30'd0, redir_vld, redir_flush}, 0);

    // R1: empty table everywhere
    for (int s = 0; s < 256; s += 7)
      do_query(8'(s), 1, 1, 0, '0, "R1");

    // Fill lower half only
    for (int i = 0; i < ENTRIES / 2; i++)
      do_call(i, AW'(16'hA000 + i * 16'h0111));

    // R2 lower half hits, R4 upper half misses
    for (int i = 0; i < ENTRIES; i++)
      do_query(sp_of(i, 3'b000, 1'b0), 1, 1, ref_v[i], ref_a[i], i < 8 ? "R2" : "R4");

    // R5: same-cycle write and read of an empty slot
    call_vld = 1; call_sp = sp_of(12, 3'b000, 1'b0); call_ret_addr = 16'h5A5A;
    fq_vld = 1; fq_is_ret = 1; fq_sp = sp_of(12, 3'b101, 1'b1);
    #1;
    chk(pred_vld == 1'b1, "R5", {31'd0, pred_vld}, 1);
    chk(pred_tgt == 16'h5A5A, "R5", {16'd0, pred_tgt}, 32'h5A5A);
    @(negedge clk);
    call_vld = 0; fq_vld = 0; fq_is_ret = 0;
    ref_v[12] = 1; ref_a[12] = 16'h5A5A;

    // Fill the rest
    for (int i = ENTRIES / 2; i < ENTRIES; i++)
      if (i != 12) do_call(i, AW'(16'hC003 + i * 16'h1021));

    // R6: aliased stack pointers, every slot, every upper pattern sample
    for (int i = 0; i < ENTRIES; i++)
      for (int h = 0; h < 8; h += 3)
        do_query(sp_of(i, 3'(h), h[0]), 1, 1, 1, ref_a[i], "R6");

    // R3: gating by strobe and return flag
    for (int i = 0; i < ENTRIES; i += 5) begin
      do_query(sp_of(i, 3'b000, 1'b0), 1, 0, 0, '0, "R3");
      do_query(sp_of(i, 3'b000, 1'b0), 0, 1, 0, '0, "R3");
    end

    // R11: overwrite
    do_call(5, 16'h1234);
    do_query(sp_of(5, 3'b010, 1'b0), 1, 1, 1, 16'h1234, "R11");
    do_query(sp_of(6, 3'b000, 1'b0), 1, 1, 1, ref_a[6], "R11 neighbour untouched");

    // R7..R10: resolution sweep incl. wrap
    for (int k = 0; k < 24; k++) begin
      logic [AW-1:0] pop;
      pop = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h00FF : AW'(k * 16'h0B37 + 16'h4F);
      do_resolve(0, '0, pop, "R10");
      do_resolve(1, AW'(pop + 1), pop, "R8");
      do_resolve(1, AW'(pop + 2), pop, "R9");
      do_resolve(1, pop, pop, "R9");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule